// File: doc/BRIEF.md
# SAR Conversion Accelerator

This block shortens a firmware-driven successive-approximation conversion. Software loads a small control word that holds a step count, a comparator-invert flag and a comparator column number. From then on, every read-modify-write that the CPU makes to the switched-capacitor DAC register is treated as one conversion step. On each step the block looks at the comparator result from the chosen column. It clears or keeps the bit that was tried on the previous step, and in the same write it sets the next lower trial bit.

The CPU therefore runs a short chain of identical read-modify-write instructions, one per result bit, with no branches. When the count runs out, writes reach the DAC register unchanged. The analog DAC and the comparators are not part of the block. They are seen only through the write data path and a one-bit-per-column comparator bus.

Top module: `sar_step_assist`

## Requirements
- R1: After reset the step count and the trial position are zero, `cfg_rdata` reads 0, and `dac_wdata` equals `cpu_wdata`.
- R2: A control write takes effect in the next cycle. The control word is laid out as count in bits [6:3], invert flag in bit 2 and column in bits [1:0], and `cfg_rdata` returns the live count, the invert flag and the column in that same layout.
- R3: A count field larger than DATA_W (8) is loaded as DATA_W, so the first trial bit is then the top data bit.
- R4: On a step, bit `count-1` of the write data is cleared when the decision is 0 and passed through as written when it is 1. Bit `count-2` is forced to 1, and all other bits pass through.
- R5: The decision is the comparator bit of the selected column, XORed with the invert flag. The other columns have no effect.
- R6: Each step lowers the count by one and moves the trial position down by one bit. A run started with the trial bit set converges to the input value, and the count then reads 0.
- R7: On the step with count 1, only bit 0 is decided and no bit is set.
- R8: With a count of zero, writes pass through unmodified and the state does not change.
- R9: When a control write and a CPU write fall in the same cycle, the data is modified using the old state, and the new control word is what gets loaded.
- R10: Cycles with no CPU write leave the count and the trial position unchanged, whatever the comparator inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 7 | Control word: count [6:3], invert [2], column [1:0] |
| cfg_rdata | output | 7 | Readback of live count, invert flag and column |
| cmp_col | input | 4 | Comparator result, one bit per column |
| cpu_wr | input | 1 | CPU read-modify-write to the DAC register this cycle |
| cpu_wdata | input | 8 | Data the CPU writes back |
| dac_wdata | output | 8 | Data delivered to the DAC register |

## Verification
Several properties are checked on every cycle: the count drops by exactly one and the trial position shifts by exactly one per step, the trial position stays one-hot or empty, an idle count leaves the data untouched, the last step changes no bit above bit 0, the count never exceeds the data width, and idle cycles hold the state. The bench alone can show that the keep-or-clear choice follows the selected column and the invert flag, and that whole runs converge to the input value. The same applies to clamping of large counts and to the priority of a control write that coincides with a CPU write.

// File: rtl/sar_assist_pkg.sv
package sar_assist_pkg;

   typedef enum logic {
      DEC_CLEAR = 1'b0,
      DEC_KEEP  = 1'b1
   } sar_dec_e;

   // Result bit for one data position during a conversion step.
   function automatic logic merge_bit(input logic     cpu_b,
                                      input logic     trial_b,
                                      input logic     lower_b,
                                      input sar_dec_e dec);
      logic r;
      if (trial_b && (dec == DEC_CLEAR)) r = 1'b0;
      else                               r = cpu_b | lower_b;
      return r;
   endfunction

endpackage

// File: rtl/sar_ctrl_reg.sv
module sar_ctrl_reg #(
   parameter int DATA_W = 8,
   parameter int CNT_W  = 4,
   parameter int COL_W  = 2,
   localparam int CTRL_W = CNT_W + 1 + COL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [CTRL_W-1:0] cfg_wdata,
   output logic [CNT_W-1:0]  load_cnt,
   output logic              inv_q,
   output logic [COL_W-1:0]  col_q
);

   logic [CNT_W-1:0] cnt_field;
   assign cnt_field = cfg_wdata[CTRL_W-1 -: CNT_W];

   generate
      if ((2 ** CNT_W) - 1 > DATA_W) begin : g_clamp
         assign load_cnt = (cnt_field > CNT_W'(DATA_W)) ? CNT_W'(DATA_W) : cnt_field;
      end else begin : g_pass
         assign load_cnt = cnt_field;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         inv_q <= 1'b0;
         col_q <= '0;
      end else if (cfg_we) begin
         inv_q <= cfg_wdata[COL_W];
         col_q <= cfg_wdata[COL_W-1:0];
      end
   end

endmodule

// File: rtl/sar_step_seq.sv
module sar_step_seq #(
   parameter int DATA_W = 8,
   parameter int CNT_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [CNT_W-1:0]  load_cnt,
   input  logic              wr,
   output logic              step,
   output logic [CNT_W-1:0]  cnt_q,
   output logic [DATA_W-1:0] trial_q
);

   assign step = wr && (cnt_q != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         trial_q <= '0;
      end else if (load) begin
         cnt_q   <= load_cnt;
         trial_q <= (load_cnt == '0) ? '0 : (DATA_W'(1) << (load_cnt - 1'b1));
      end else if (step) begin
         cnt_q   <= cnt_q - 1'b1;
         trial_q <= trial_q >> 1;
      end
   end

endmodule

// File: rtl/sar_bit_merge.sv
module sar_bit_merge
   import sar_assist_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int NUM_COL = 4,
   parameter int COL_W   = 2
) (
   input  logic [NUM_COL-1:0] cmp_col,
   input  logic [COL_W-1:0]   col,
   input  logic               inv,
   input  logic               step,
   input  logic [DATA_W-1:0]  trial,
   input  logic [DATA_W-1:0]  cpu_wdata,
   output logic [DATA_W-1:0]  dac_wdata
);

   logic     cmp_sel;
   sar_dec_e dec;

   generate
      if (NUM_COL == 1) begin : g_single
         assign cmp_sel = cmp_col[0];
      end else begin : g_mux
         assign cmp_sel = cmp_col[col];
      end
   endgenerate

   assign dec = sar_dec_e'(cmp_sel ^ inv);

   generate
      for (genvar i = 0; i < DATA_W; i++) begin : g_bit
         logic lower;
         if (i < DATA_W - 1) begin : g_low
            assign lower = trial[i+1];
         end else begin : g_top
            assign lower = 1'b0;
         end
         assign dac_wdata[i] = step ? merge_bit(cpu_wdata[i], trial[i], lower, dec)
                                    : cpu_wdata[i];
      end
   endgenerate

endmodule

// File: rtl/sar_step_assist.sv
module sar_step_assist #(
   parameter int DATA_W  = 8,
   parameter int CNT_W   = 4,
   parameter int NUM_COL = 4,
   localparam int COL_W  = (NUM_COL > 1) ? $clog2(NUM_COL) : 1,
   localparam int CTRL_W = CNT_W + 1 + COL_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  logic [CTRL_W-1:0]  cfg_wdata,
   output logic [CTRL_W-1:0]  cfg_rdata,
   input  logic [NUM_COL-1:0] cmp_col,
   input  logic               cpu_wr,
   input  logic [DATA_W-1:0]  cpu_wdata,
   output logic [DATA_W-1:0]  dac_wdata
);

   generate
      if (DATA_W < 2) begin : g_bad_data_w
         $error("sar_step_assist: DATA_W must be at least 2");
      end
      if (CNT_W < 1) begin : g_bad_cnt_w
         $error("sar_step_assist: CNT_W must be at least 1");
      end
      if (NUM_COL < 1) begin : g_bad_cols
         $error("sar_step_assist: NUM_COL must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0]  load_cnt;
   logic              inv_q;
   logic [COL_W-1:0]  col_q;
   logic              step;
   logic [CNT_W-1:0]  cnt_q;
   logic [DATA_W-1:0] trial_q;

   sar_ctrl_reg #(
      .DATA_W (DATA_W),
      .CNT_W  (CNT_W),
      .COL_W  (COL_W)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_wdata (cfg_wdata),
      .load_cnt  (load_cnt),
      .inv_q     (inv_q),
      .col_q     (col_q)
   );

   sar_step_seq #(
      .DATA_W (DATA_W),
      .CNT_W  (CNT_W)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (cfg_we),
      .load_cnt (load_cnt),
      .wr       (cpu_wr),
      .step     (step),
      .cnt_q    (cnt_q),
      .trial_q  (trial_q)
   );

   sar_bit_merge #(
      .DATA_W  (DATA_W),
      .NUM_COL (NUM_COL),
      .COL_W   (COL_W)
   ) u_merge (
      .cmp_col   (cmp_col),
      .col       (col_q),
      .inv       (inv_q),
      .step      (step),
      .trial     (trial_q),
      .cpu_wdata (cpu_wdata),
      .dac_wdata (dac_wdata)
   );

   assign cfg_rdata = {cnt_q, inv_q, col_q};

endmodule

// File: rtl/sar_assist_chk.sv
module sar_assist_chk #(
   parameter int DATA_W = 8,
   parameter int CNT_W  = 4,
   parameter int COL_W  = 2,
   localparam int CTRL_W = CNT_W + 1 + COL_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_we,
   input logic [CTRL_W-1:0] cfg_wdata,
   input logic [CTRL_W-1:0] cfg_rdata,
   input logic              cpu_wr,
   input logic [DATA_W-1:0] cpu_wdata,
   input logic [DATA_W-1:0] dac_wdata,
   input logic              step,
   input logic [CNT_W-1:0]  cnt_q,
   input logic [DATA_W-1:0] trial_q
);

   // R2
   cfg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we |=> cfg_rdata[COL_W:0] == $past(cfg_wdata[COL_W:0]));

   // R3
   cnt_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_W'(DATA_W));

   // R6
   cnt_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !cfg_we) |=> cnt_q == $past(cnt_q) - 1'b1);

   // R6
   trial_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !cfg_we) |=> trial_q == ($past(trial_q) >> 1));

   // R6
   trial_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(trial_q) && ((cnt_q == '0) == (trial_q == '0)));

   // R7
   last_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wr && cnt_q == CNT_W'(1)) |-> dac_wdata[DATA_W-1:1] == cpu_wdata[DATA_W-1:1]);

   // R8
   idle_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == '0) |-> dac_wdata == cpu_wdata);

   // R10
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cpu_wr && !cfg_we) |=> $stable(cnt_q) && $stable(trial_q));

endmodule

bind sar_step_assist sar_assist_chk #(
   .DATA_W (DATA_W),
   .CNT_W  (CNT_W),
   .COL_W  (COL_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_we    (cfg_we),
   .cfg_wdata (cfg_wdata),
   .cfg_rdata (cfg_rdata),
   .cpu_wr    (cpu_wr),
   .cpu_wdata (cpu_wdata),
   .dac_wdata (dac_wdata),
   .step      (step),
   .cnt_q     (cnt_q),
   .trial_q   (trial_q)
);

// File: tb/test_sar_step_assist.sv
module test_sar_step_assist;

   localparam int CLK_P = 10;
   localparam int NV    = 8;

   // count[14:11], invert[10], column[9:8], input value[7:0]
   localparam logic [14:0] VEC [NV] = '{
      {4'd6, 1'b0, 2'd0, 8'h2B},
      {4'd6, 1'b1, 2'd2, 8'h11},
      {4'd4, 1'b0, 2'd3, 8'h09},
      {4'd8, 1'b0, 2'd1, 8'hA5},
      {4'd1, 1'b1, 2'd1, 8'h01},
      {4'd3, 1'b0, 2'd2, 8'h00},
      {4'd8, 1'b1, 2'd3, 8'hFF},
      {4'd2, 1'b0, 2'd0, 8'h02}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_we = 1'b0;
   logic [6:0] cfg_wdata = '0;
   logic [6:0] cfg_rdata;
   logic [3:0] cmp_col = '0;
   logic       cpu_wr = 1'b0;
   logic [7:0] cpu_wdata = '0;
   logic [7:0] dac_wdata;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   logic [3:0] v_n;
   logic       v_inv;
   logic [1:0] v_col;
   logic [7:0] v_in;
   logic [7:0] dac, exp_d, got;
   logic       keep, raw;
   logic [3:0] cmpv;
   int         tb_bit;

   sar_step_assist i_sar_step_assist (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_wdata (cfg_wdata),
      .cfg_rdata (cfg_rdata),
      .cmp_col   (cmp_col),
      .cpu_wr    (cpu_wr),
      .cpu_wdata (cpu_wdata),
      .dac_wdata (dac_wdata)
   );

   always #(CLK_P/2) clk = ~clk;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
      n_tests++;
      if (act !== expv) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
      end
   endtask

   // Called just after a falling edge; returns just after the next one.
   task automatic cfg_write(input logic [6:0] w);
      cfg_we = 1'b1;
      cfg_wdata = w;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic rmw(input logic [7:0] d, input logic [3:0] c);
      cpu_wr = 1'b1;
      cpu_wdata = d;
      cmp_col = c;
      #1;
      got = dac_wdata;
      @(negedge clk);
      cpu_wr = 1'b0;
   endtask

   initial begin
      #(CLK_P * 100000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state and pass-through
      chk("R1 readback", cfg_rdata, 7'h00);
      rmw(8'h5A, 4'hF);
      chk("R1 pass-through", got, 8'h5A);
      chk("R1 state kept", cfg_rdata, 7'h00);

      // Table of full conversions: R2, R4, R5, R6, R7, R8
      for (int v = 0; v < NV; v++) begin
         v_n   = VEC[v][14:11];
         v_inv = VEC[v][10];
         v_col = VEC[v][9:8];
         v_in  = VEC[v][7:0];
         cfg_write({v_n, v_inv, v_col});
         chk("R2 load", cfg_rdata, {v_n, v_inv, v_col});
         dac = 8'(1) << (v_n - 1);
         for (int s = 0; s < int'(v_n); s++) begin
            tb_bit = int'(v_n) - 1 - s;
            keep = (dac <= v_in);
            raw  = keep ^ v_inv;
            cmpv = {4{~raw}};
            cmpv[v_col] = raw;
            exp_d = keep ? dac : (dac & ~(8'(1) << tb_bit));
            if (tb_bit > 0) exp_d = exp_d | (8'(1) << (tb_bit - 1));
            rmw(dac, cmpv);
            if (tb_bit == 0)  chk("R7 last step", got, exp_d);
            else if (v_inv)   chk("R5 inverted step", got, exp_d);
            else              chk("R4 step", got, exp_d);
            dac = exp_d;
         end
         chk("R6 converged", dac, v_in);
         chk("R6 count zero", cfg_rdata[6:3], 4'd0);
         rmw(8'h3C, 4'hF);
         chk("R8 pass when idle", got, 8'h3C);
         chk("R8 state kept", cfg_rdata[6:3], 4'd0);
      end

      // R3: oversize count clamps to 8; first trial is bit 7
      cfg_write({4'd15, 1'b0, 2'd1});
      chk("R3 clamp", cfg_rdata, {4'd8, 1'b0, 2'd1});
      rmw(8'h80, 4'b0010);
      chk("R3 top trial", got, 8'hC0);

      // R10: idle cycles with toggling comparators hold the state
      cmp_col = 4'hF;
      @(negedge clk);
      cmp_col = 4'h0;
      @(negedge clk);
      cmp_col = 4'hA;
      @(negedge clk);
      chk("R10 hold", cfg_rdata, {4'd7, 1'b0, 2'd1});
      rmw(8'h40, 4'b0010);
      chk("R10 trial kept", got, 8'h60);

      // R9: control write coinciding with a CPU write
      cfg_write({4'd5, 1'b0, 2'd0});
      cfg_we = 1'b1;
      cfg_wdata = {4'd3, 1'b0, 2'd2};
      rmw(8'h10, 4'b0100);
      cfg_we = 1'b0;
      chk("R9 old state used", got, 8'h08);
      chk("R9 new word loaded", cfg_rdata, {4'd3, 1'b0, 2'd2});

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule